// File: doc/BRIEF.md
# Function-Select Arithmetic/Logic Unit

This block is a purely combinational arithmetic and logic unit of configurable width. Two unsigned operands enter on `op_a` and `op_b`. A 3-bit function code on `fn` picks one of six operations: sum, difference, decrement of the first operand, bitwise AND, bitwise OR, and bitwise inversion of the first operand. The selected result appears on `y` in the same cycle.

Beside the result, the unit drives three flags. `carry` holds the carry out of an addition, or the borrow of a subtraction or a decrement. `zero` marks an all-zero result. `a_gt_b` reports an unsigned magnitude comparison of the two operands. The function code comes from decode logic elsewhere. The unit stores nothing, so the surrounding pipeline registers its outputs.

Top module: `alu_fsel`

## Requirements
- R1: With `fn` = 3'b000, `y` equals (`op_a` + `op_b`) modulo 2^W, and `carry` is the bit of weight 2^W of the full sum.
- R2: With `fn` = 3'b001, `y` equals (`op_a` − `op_b`) modulo 2^W, and `carry` is 1 exactly when `op_b` > `op_a` (unsigned borrow).
- R3: With `fn` = 3'b010, `y` equals (`op_a` − 1) modulo 2^W, and `carry` is 1 exactly when `op_a` is zero.
- R4: With `fn` = 3'b011, `y` equals `op_a` AND `op_b` bit by bit, and `carry` is 0.
- R5: With `fn` = 3'b100, `y` equals `op_a` OR `op_b` bit by bit, and `carry` is 0.
- R6: With `fn` = 3'b101, `y` equals the bitwise inverse of `op_a`, `op_b` has no effect, and `carry` is 0.
- R7: With `fn` = 3'b110 or 3'b111, `y` is all zeros and `carry` is 0, whatever the operands are.
- R8: `zero` is 1 exactly when every bit of `y` is 0, for every function code.
- R9: `a_gt_b` is 1 exactly when `op_a` > `op_b` as unsigned numbers, whatever the value of `fn`.
- R10: The operand and result width W is a parameter with a default of 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| fn | input | 3 | Function code |
| y | output | W | Result |
| carry | output | 1 | Carry out of a sum, or borrow of a difference or decrement; 0 otherwise |
| zero | output | 1 | Result is all zeros |
| a_gt_b | output | 1 | Unsigned `op_a` > `op_b` |

## Verification
The directed cases target the wrap points. They add all-ones to one, which checks that a carry-out dropped on a full-width sum is noticed. They subtract a larger value from a smaller one, so an inverted borrow polarity shows up. They decrement zero, where a design that forgets the borrow leaves `carry` low with `y` at all ones. Equal operands exercise `a_gt_b`, so a design using greater-or-equal fails there. The spare codes run with non-zero operands, so logic that falls through to an arithmetic or logic case would leak a non-zero result. Random vectors then sweep every code with the comparison and zero flag checked on each, which catches a flag that is tied to one function or computed signed.

// File: rtl/alu_fsel.sv
module alu_fsel #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   fn,
  output logic [W-1:0] y,
  output logic         carry,
  output logic         zero,
  output logic         a_gt_b
);

  localparam logic [2:0] FN_ADD = 3'b000;
  localparam logic [2:0] FN_SUB = 3'b001;
  localparam logic [2:0] FN_DEC = 3'b010;
  localparam logic [2:0] FN_AND = 3'b011;
  localparam logic [2:0] FN_OR  = 3'b100;
  localparam logic [2:0] FN_NOT = 3'b101;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W:0] wide;

  always_comb begin
    case (fn)
      FN_ADD:  wide = {1'b0, op_a} + {1'b0, op_b};
      FN_SUB:  wide = {1'b0, op_a} - {1'b0, op_b};
      FN_DEC:  wide = {1'b0, op_a} - {1'b0, ONE};
      FN_AND:  wide = {1'b0, op_a & op_b};
      FN_OR:   wide = {1'b0, op_a | op_b};
      FN_NOT:  wide = {1'b0, ~op_a};
      default: wide = '0;
    endcase
  end

  assign y      = wide[W-1:0];
  assign carry  = wide[W];
  assign zero   = ~|y;
  assign a_gt_b = op_a > op_b;

  always_comb begin
    if (fn == FN_ADD) begin
      a_r1_add_sum: assert ((y - op_b) == op_a && carry == (y < op_a))
        else $error("R1 sum or carry wrong");
    end
    if (fn == FN_SUB) begin
      a_r2_sub_diff: assert ((y + op_b) == op_a && carry == (op_a < op_b))
        else $error("R2 difference or borrow wrong");
    end
    if (fn == FN_DEC) begin
      a_r3_dec_borrow: assert ((y + ONE) == op_a && carry == (y == '1))
        else $error("R3 decrement or borrow wrong");
    end
    if (fn == FN_AND || fn == FN_OR || fn == FN_NOT) begin
      a_r4_logic_no_carry: assert (!carry)
        else $error("R4 R5 R6 carry set on logic op");
    end
    if (fn == FN_NOT) begin
      a_r6_not_inverse: assert ((y & op_a) == '0 && (y | op_a) == '1)
        else $error("R6 inverse wrong");
    end
    if (fn[2:1] == 2'b11) begin
      a_r7_spare_quiet: assert (zero && !carry)
        else $error("R7 spare code not quiet");
    end
    if (a_gt_b) begin
      a_r9_gt_strict: assert (op_a != op_b)
        else $error("R9 greater flag on equal operands");
    end
  end

endmodule

// File: tb/test_alu_fsel.sv
module test_alu_fsel;
  localparam int W = 16;
  localparam logic [W-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [2:0] fn = 3'b000;
  logic [W-1:0] y;
  logic carry, zero, a_gt_b;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alu_fsel #(.W(W)) i_alu_fsel (
    .op_a(op_a), .op_b(op_b), .fn(fn),
    .y(y), .carry(carry), .zero(zero), .a_gt_b(a_gt_b)
  );

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [2:0] f);
    logic [31:0] s;
    case (f)
      3'd0: begin s = 32'(a) + 32'(b); return s[W:0]; end
      3'd1: return {(b > a), W'(32'(a) + 32'(1 << W) - 32'(b))};
      3'd2: return {(a == 0), (a == 0) ? ALL1 : W'(32'(a) - 32'd1)};
      3'd3: return {1'b0, a & b};
      3'd4: return {1'b0, a | b};
      3'd5: return {1'b0, a ^ ALL1};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [W:0] act,
                       input logic [W:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
    logic [W:0] e;
    @(negedge clk);
    op_a = a; op_b = b; fn = f;
    #2;
    e = model(a, b, f);
    // R10: widths follow the default parameter of 16
    check({carry, y} === e, req_of(f), {carry, y}, e);
    check(zero === (e[W-1:0] == 0), "R8", {{W{1'b0}}, zero}, {{W{1'b0}}, (e[W-1:0] == 0)});
    check(a_gt_b === (a > b), "R9", {{W{1'b0}}, a_gt_b}, {{W{1'b0}}, (a > b)});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #100000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd424));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check(y === '0 && zero === 1'b1 && carry === 1'b0, "R8", {carry, y}, '0);
    apply(ALL1, 16'h0001, 3'd0);   // R1 wrap with carry
    apply(16'h8000, 16'h8000, 3'd0);
    apply(16'h0003, 16'h0005, 3'd1); // R2 borrow
    apply(16'h1234, 16'h1234, 3'd1); // R2 equal, zero result
    apply(16'h0000, 16'h0000, 3'd2); // R3 decrement of zero
    apply(16'h0001, 16'h0000, 3'd2);
    apply(16'hF0F0, 16'h0FF0, 3'd3); // R4
    apply(16'h0000, 16'h0000, 3'd4); // R5 zero
    apply(ALL1, 16'h5A5A, 3'd5);     // R6 operand b ignored
    apply(16'h1234, 16'hFFFF, 3'd5);
    apply(ALL1, ALL1, 3'd6);         // R7
    apply(16'h7FFF, 16'h0001, 3'd7); // R7
    for (int f = 0; f < 8; f++) apply(16'h4242, 16'h4242, 3'(f)); // R9 equal operands
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (i % 16 == 0) rb = ra;
      apply(ra, rb, 3'($urandom % 8));
    end
    finished = 1;
    summary();
  end
endmodule